// File: doc/BRIEF.md
# UART FIFO Threshold and Flush Controller

This block contains the receive and transmit byte queues of a UART together with the logic that decides when each queue has reached its service point. The serial side pushes received bytes into the receive queue and pops bytes to send from the transmit queue. The host side does the reverse. A single 8-bit control write configures the queues. It can turn deep buffering on or off, flush either queue, choose a DMA signalling mode and pick two 2-bit threshold codes.

The threshold for each direction comes from one of three schemes. The first is a fixed four-entry table. The second is a coarse 4-bit extension value that counts in steps of four. The third is a fine 6-bit value formed from the extension value and the 2-bit code. Two status inputs guard the configuration. One shows that the baud divisor is zero, which unlocks the enable and DMA bits. The other enables the extended feature set, which unlocks the transmit threshold code. The block outputs a receive-threshold flag, a transmit-room flag, two DMA request lines and both queue levels.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After reset, every control field is 0, both levels are 0, `rx_trig_hit` is 0, `tx_space_ok` is 1 and `dma_req` is 0.
- R2: Each queue holds 64 bytes in first-in first-out order while deep buffering is on, and 1 byte while it is off. A push into a full queue is dropped. A pop from an empty queue has no effect. The read data port shows the oldest entry.
- R3: When `rx_fine` is 0 and `rx_ext_nib` is 0, receive code (control bits 7:6) values 0, 1, 2 and 3 give thresholds of 8, 16, 56 and 60 bytes.
- R4: When `tx_fine` is 0 and `tx_ext_nib` is 0, transmit code (control bits 5:4) values 0, 1, 2 and 3 give thresholds of 8, 16, 32 and 56 free entries.
- R5: When the fine bit is 0 and the extension value N is nonzero, the threshold is 4×N and the 2-bit code is ignored.
- R6: When the fine bit is 1, the threshold is N×4 plus the 2-bit code. A computed value of 0 is treated as 1.
- R7: `rx_trig_hit` is 1 exactly when the receive level is at least the receive threshold. `tx_space_ok` is 1 exactly when 64 minus the transmit level is at least the transmit threshold.
- R8: A control write with bit 1 set empties the receive queue, and a control write with bit 2 set empties the transmit queue. The flush is visible in the cycle after the write, and it takes priority over a push or pop in the same cycle. These bits are not stored.
- R9: Enable (bit 0) and DMA mode (bit 3) take a new value only when a write occurs while `div_zero` is 1. Otherwise they keep their old values.
- R10: The transmit code takes a new value only when a write occurs while `enh_en` is 1. The receive code takes a new value on every write.
- R11: In DMA mode 1, `dma_req[0]` equals `tx_space_ok` and `dma_req[1]` equals `rx_trig_hit`. In DMA mode 0, both request lines are 0.
- R12: An accepted write that changes the enable bit empties both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_wdata | input | 8 | Control write data |
| div_zero | input | 1 | Baud divisor is zero |
| enh_en | input | 1 | Extended features enabled |
| rx_fine | input | 1 | Fine threshold granularity, receive |
| tx_fine | input | 1 | Fine threshold granularity, transmit |
| rx_ext_nib | input | 4 | Receive threshold extension value |
| tx_ext_nib | input | 4 | Transmit threshold extension value |
| rx_push | input | 1 | Write a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Read the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| tx_push | input | 1 | Write a byte to send |
| tx_wdata | input | 8 | Byte to send |
| tx_pop | input | 1 | Take the oldest byte to send |
| tx_rdata | output | 8 | Oldest byte to send |
| rx_level | output | 7 | Receive queue occupancy |
| tx_level | output | 7 | Transmit queue occupancy |
| rx_trig_hit | output | 1 | Receive threshold reached |
| tx_space_ok | output | 1 | Transmit room at or above threshold |
| dma_req | output | 2 | DMA requests: bit 0 transmit, bit 1 receive |

## Verification
The directed probes fill a queue to one entry below each threshold and then to the threshold itself. They do this in table, coarse and fine modes, which shows an off-by-one in the comparison and a wrong table entry apart from a wrong scheme choice. The random phase mixes pushes, pops, flushes, threshold changes and toggles of `div_zero` and `enh_en`. Against a reference model, this shows whether a locked field leaked through and whether a flush lost its priority. A run with buffering off checks the one-byte capacity, so a missing capacity switch is caught.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
   localparam int unsigned TRIG_W = 6;

   // Extended threshold: fine = nibble:code, coarse = nibble*4; zero clamps to 1.
   function automatic logic [TRIG_W-1:0] ext_trig(input logic fine,
                                                  input logic [3:0] nib,
                                                  input logic [1:0] code);
      logic [TRIG_W-1:0] v;
      v = fine ? {nib, code} : {nib, 2'b00};
      if (v == '0) v = TRIG_W'(1);
      return v;
   endfunction
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          deep,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [LW-1:0] level
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("uart_byte_fifo: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [LW-1:0] cap;
   logic          do_push, do_pop;

   assign cap     = deep ? LW'(DEPTH) : LW'(1);
   assign do_push = push && (level < cap) && !flush;
   assign do_pop  = pop && (level != '0) && !flush;
   assign dout    = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         level <= level + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end
endmodule

// File: rtl/uart_trig_sel.sv
module uart_trig_sel
   import uart_fifo_pkg::*;
#(
   parameter bit IS_RX = 1'b1
) (
   input  logic              fine,
   input  logic [3:0]        nib,
   input  logic [1:0]        code,
   output logic [TRIG_W-1:0] trig
);
   logic [TRIG_W-1:0] tbl;

   if (IS_RX) begin : g_rx_tbl
      always_comb begin
         unique case (code)
            2'd0: tbl = TRIG_W'(8);
            2'd1: tbl = TRIG_W'(16);
            2'd2: tbl = TRIG_W'(56);
            default: tbl = TRIG_W'(60);
         endcase
      end
   end else begin : g_tx_tbl
      always_comb begin
         unique case (code)
            2'd0: tbl = TRIG_W'(8);
            2'd1: tbl = TRIG_W'(16);
            2'd2: tbl = TRIG_W'(32);
            default: tbl = TRIG_W'(56);
         endcase
      end
   end

   assign trig = (!fine && nib == 4'd0) ? tbl : ext_trig(fine, nib, code);
endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
module uart_fifo_trig_ctrl
   import uart_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DW    = 8,
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [7:0]    cfg_wdata,
   input  logic          div_zero,
   input  logic          enh_en,
   input  logic          rx_fine,
   input  logic          tx_fine,
   input  logic [3:0]    rx_ext_nib,
   input  logic [3:0]    tx_ext_nib,
   input  logic          rx_push,
   input  logic [DW-1:0] rx_wdata,
   input  logic          rx_pop,
   output logic [DW-1:0] rx_rdata,
   input  logic          tx_push,
   input  logic [DW-1:0] tx_wdata,
   input  logic          tx_pop,
   output logic [DW-1:0] tx_rdata,
   output logic [LW-1:0] rx_level,
   output logic [LW-1:0] tx_level,
   output logic          rx_trig_hit,
   output logic          tx_space_ok,
   output logic [1:0]    dma_req
);
   if (DEPTH < 64) begin : g_bad_depth
      $error("uart_fifo_trig_ctrl: DEPTH must cover the 6-bit threshold range");
   end

   logic       en_q, dma_q;
   logic [1:0] rx_code_q, tx_code_q;
   logic       lock_ok, en_flip, rx_flush, tx_flush;
   logic [TRIG_W-1:0] rx_trig, tx_trig;
   logic [LW-1:0]     tx_room;

   assign lock_ok  = cfg_wr && div_zero;
   assign en_flip  = lock_ok && (cfg_wdata[0] != en_q);
   assign rx_flush = (cfg_wr && cfg_wdata[1]) || en_flip;
   assign tx_flush = (cfg_wr && cfg_wdata[2]) || en_flip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         dma_q     <= 1'b0;
         rx_code_q <= '0;
         tx_code_q <= '0;
      end else if (cfg_wr) begin
         rx_code_q <= cfg_wdata[7:6];
         if (enh_en) tx_code_q <= cfg_wdata[5:4];
         if (div_zero) begin
            en_q  <= cfg_wdata[0];
            dma_q <= cfg_wdata[3];
         end
      end
   end

   uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .deep(en_q), .flush(rx_flush),
      .push(rx_push), .din(rx_wdata), .pop(rx_pop),
      .dout(rx_rdata), .level(rx_level)
   );

   uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .deep(en_q), .flush(tx_flush),
      .push(tx_push), .din(tx_wdata), .pop(tx_pop),
      .dout(tx_rdata), .level(tx_level)
   );

   uart_trig_sel #(.IS_RX(1'b1)) u_rx_trig (
      .fine(rx_fine), .nib(rx_ext_nib), .code(rx_code_q), .trig(rx_trig)
   );

   uart_trig_sel #(.IS_RX(1'b0)) u_tx_trig (
      .fine(tx_fine), .nib(tx_ext_nib), .code(tx_code_q), .trig(tx_trig)
   );

   assign tx_room     = LW'(DEPTH) - tx_level;
   assign rx_trig_hit = rx_level >= LW'(rx_trig);
   assign tx_space_ok = tx_room >= LW'(tx_trig);
   assign dma_req     = dma_q ? {rx_trig_hit, tx_space_ok} : 2'b00;
endmodule

// File: rtl/uart_fifo_trig_ctrl_chk.sv
module uart_fifo_trig_ctrl_chk #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_wr,
   input logic [7:0]    cfg_wdata,
   input logic          div_zero,
   input logic          en_q,
   input logic          dma_q,
   input logic          rx_push,
   input logic          rx_pop,
   input logic [LW-1:0] rx_level,
   input logic [LW-1:0] tx_level,
   input logic          rx_trig_hit,
   input logic          tx_space_ok,
   input logic [1:0]    dma_req
);
   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));

   // R2
   shallow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (rx_level <= LW'(1)) && (tx_level <= LW'(1)));

   // R8
   rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[1]) |=> (rx_level == '0));

   // R8
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[2]) |=> (tx_level == '0));

   // R9
   en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cfg_wr && div_zero)) |=> $stable(en_q) && $stable(dma_q));

   // R11
   dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_q |-> (dma_req == 2'b00));

   // R7
   rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> !rx_trig_hit);

   // R7
   tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == '0) |-> tx_space_ok);

   // R2
   rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0 && rx_pop && !rx_push) |=> (rx_level == '0));
endmodule

bind uart_fifo_trig_ctrl uart_fifo_trig_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
   .div_zero(div_zero), .en_q(en_q), .dma_q(dma_q),
   .rx_push(rx_push), .rx_pop(rx_pop),
   .rx_level(rx_level), .tx_level(tx_level),
   .rx_trig_hit(rx_trig_hit), .tx_space_ok(tx_space_ok), .dma_req(dma_req)
);

// File: tb/uart_fifo_trig_ctrl_tb.sv
module uart_fifo_trig_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 64;

   logic       clk = 0, rst_n = 0;
   logic       cfg_wr = 0;
   logic [7:0] cfg_wdata = 0;
   logic       div_zero = 1, enh_en = 1, rx_fine = 0, tx_fine = 0;
   logic [3:0] rx_ext_nib = 0, tx_ext_nib = 0;
   logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
   logic [7:0] rx_wdata = 0, tx_wdata = 0, rx_rdata, tx_rdata;
   logic [6:0] rx_level, tx_level;
   logic       rx_trig_hit, tx_space_ok;
   logic [1:0] dma_req;

   int checks = 0, errors = 0;
   bit m_en = 0, m_dma = 0;
   bit [1:0] m_rxc = 0, m_txc = 0;
   byte unsigned rxq[$], txq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_fifo_trig_ctrl dut_i (.*);

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic int thr(bit rx, bit fine, bit [3:0] nib, bit [1:0] c);
      int v;
      if (fine) v = nib * 4 + c;
      else if (nib != 0) v = nib * 4;
      else if (rx) v = (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 56 : 60;
      else v = (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 32 : 56;
      return (v == 0) ? 1 : v;
   endfunction

   function automatic bit exp_rx_hit();
      return rxq.size() >= thr(1, rx_fine, rx_ext_nib, m_rxc);
   endfunction
   function automatic bit exp_tx_ok();
      return (DEPTH - txq.size()) >= thr(0, tx_fine, tx_ext_nib, m_txc);
   endfunction

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2 rx_level", rx_level, rxq.size());
      chk("R2 tx_level", tx_level, txq.size());
      if (rxq.size() > 0) chk("R2 rx_rdata", rx_rdata, rxq[0]);
      if (txq.size() > 0) chk("R2 tx_rdata", tx_rdata, txq[0]);
      chk("R7 rx_trig_hit", rx_trig_hit, exp_rx_hit());
      chk("R7 tx_space_ok", tx_space_ok, exp_tx_ok());
      chk("R11 dma_req", dma_req,
          m_dma ? {exp_rx_hit(), exp_tx_ok()} : 0);
   endtask

   // one clock: drive after negedge, update model, sample after posedge
   task automatic step(bit wr, bit [7:0] wd, bit rp, bit rq, bit tp, bit tq);
      bit rfl, tfl;
      int cap;
      byte unsigned rd, td;
      rd = 8'($urandom); td = 8'($urandom);
      cfg_wr = wr; cfg_wdata = wd;
      rx_push = rp; rx_pop = rq; rx_wdata = rd;
      tx_push = tp; tx_pop = tq; tx_wdata = td;
      cap = m_en ? DEPTH : 1;
      rfl = wr && wd[1]; tfl = wr && wd[2];
      if (wr) begin
         if (div_zero) begin
            if (wd[0] != m_en) begin rfl = 1; tfl = 1; end
            m_en = wd[0]; m_dma = wd[3];
         end
         m_rxc = wd[7:6];
         if (enh_en) m_txc = wd[5:4];
      end
      if (rfl) rxq.delete();
      else begin
         bit okp = rp && rxq.size() < cap;
         if (rq && rxq.size() > 0) void'(rxq.pop_front());
         if (okp) rxq.push_back(rd);
      end
      if (tfl) txq.delete();
      else begin
         bit okp = tp && txq.size() < cap;
         if (tq && txq.size() > 0) void'(txq.pop_front());
         if (okp) txq.push_back(td);
      end
      @(posedge clk); #1;
      compare_all();
      @(negedge clk);
      cfg_wr = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
   endtask

   function automatic bit [7:0] cfgb(bit [1:0] rc, bit [1:0] tc, bit dma, bit en);
      return {rc, tc, dma, 2'b00, en};
   endfunction

   task automatic rx_probe(string tag, int t, bit [7:0] cfg);
      step(1, cfg | 8'h02, 0, 0, 0, 0);
      chk({tag, " R8 flush"}, rx_level, 0);
      for (int i = 0; i < t - 1; i++) step(0, 0, 1, 0, 0, 0);
      chk({tag, " below"}, rx_trig_hit, 0);
      step(0, 0, 1, 0, 0, 0);
      chk({tag, " at"}, rx_trig_hit, 1);
   endtask

   task automatic tx_probe(string tag, int t, bit [7:0] cfg);
      step(1, cfg | 8'h04, 0, 0, 0, 0);
      for (int i = 0; i < DEPTH - t + 1; i++) step(0, 0, 0, 0, 1, 0);
      chk({tag, " below"}, tx_space_ok, 0);
      step(0, 0, 0, 0, 0, 1);
      chk({tag, " at"}, tx_space_ok, 1);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rx_level", rx_level, 0);
      chk("R1 tx_level", tx_level, 0);
      chk("R1 rx_trig_hit", rx_trig_hit, 0);
      chk("R1 tx_space_ok", tx_space_ok, 1);
      chk("R1 dma_req", dma_req, 0);

      // R2 shallow mode: one entry
      step(0, 0, 1, 0, 1, 0);
      step(0, 0, 1, 0, 1, 0);
      chk("R2 shallow cap", rx_level, 1);

      // R12 enabling deep mode flushes
      step(1, cfgb(0, 0, 1, 1), 0, 0, 0, 0);
      chk("R12 rx flushed", rx_level, 0);
      chk("R12 tx flushed", tx_level, 0);

      // R3 receive table
      for (int c = 0; c < 4; c++)
         rx_probe("R3", thr(1, 0, 0, 2'(c)), cfgb(2'(c), 0, 1, 1));
      // R4 transmit table
      for (int c = 0; c < 4; c++)
         tx_probe("R4", thr(0, 0, 0, 2'(c)), cfgb(0, 2'(c), 1, 1));
      // R5 coarse
      rx_ext_nib = 5;
      rx_probe("R5", 20, cfgb(3, 0, 1, 1));
      // R6 fine, and zero clamp
      rx_fine = 1; rx_ext_nib = 2;
      rx_probe("R6", 9, cfgb(1, 0, 1, 1));
      rx_ext_nib = 0;
      rx_probe("R6 zero", 1, cfgb(0, 0, 1, 1));
      rx_fine = 0;

      // R9 locked enable/dma
      step(1, cfgb(0, 0, 1, 1) | 8'h06, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      div_zero = 0;
      step(1, cfgb(0, 0, 0, 0), 1, 0, 0, 0);
      chk("R9 enable held", rx_level, 2);
      chk("R9 dma held", dma_req[0], 1);

      // R10 transmit code locked
      enh_en = 0;
      step(1, cfgb(0, 3, 0, 0) | 8'h04, 0, 0, 0, 0);
      for (int i = 0; i < 56; i++) step(0, 0, 0, 0, 1, 0);
      chk("R10 tx code held", tx_space_ok, 1);
      enh_en = 1;

      // R8: writes without the clear bits keep data
      step(1, cfgb(0, 0, 0, 0), 0, 0, 0, 0);
      chk("R8 no clear", tx_level, 56);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         bit wr = ($urandom % 20) == 0;
         bit [7:0] wd = 8'($urandom);
         if (($urandom % 4) != 0) wd[2:1] = 0;
         if (($urandom % 10) == 0) div_zero = ~div_zero;
         if (($urandom % 10) == 0) enh_en = ~enh_en;
         if (($urandom % 50) == 0) begin
            rx_fine = 1'($urandom); tx_fine = 1'($urandom);
            rx_ext_nib = ($urandom % 3 == 0) ? 4'($urandom) : 0;
            tx_ext_nib = ($urandom % 3 == 0) ? 4'($urandom) : 0;
         end
         step(wr, wd, ($urandom % 3) != 0, ($urandom % 3) == 0,
              ($urandom % 3) != 0, ($urandom % 3) == 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule